// File: doc/BRIEF.md
# Inter-Processor Interrupt Unit

This block lets any core of a small cluster (four cores by default) raise an interrupt on any core, itself included. For each target core it keeps a record of which cores have raised an interrupt on it that has not yet been acknowledged. That record is a bit vector with one bit per sending core. The target's interrupt line is the OR of its vector, so requests from several senders merge into one asserted line.

Software drives the unit through a command port. The port carries a valid strobe, an opcode, the issuing core's number and a target field. Only one command is accepted per cycle. Query results come back in a single shared readback register. Each query command overwrites that register, and all other commands leave it alone.

Opcodes (2 bits): 0 = raise, 1 = status, 2 = source, 3 = acknowledge. For raise and status, the target field names the destination core. For acknowledge, the target field carries the index of the sender being acknowledged.

Top module: `ipi_unit`

## Requirements
- R1: After synchronous reset, every interrupt output is 0, every source vector is empty and readback is 0.
- R2: A raise command (opcode 0) from core I naming core T sets bit I of T's source vector. irq[T] is 1 on the cycle after the command.
- R3: A status command (opcode 1) from core I naming core T loads readback with 1 if bit I of T's vector is set and with 0 otherwise. The result is visible on the cycle after the command.
- R4: A source command (opcode 2) from core I loads readback with I's whole source vector, in which bit i stands for core i (a single sender reads as 1, 2, 4 or 8).
- R5: Raises from several cores to the same target leave only that target's line asserted. The target's source vector then shows one bit per sender.
- R6: An acknowledge command (opcode 3) from core I whose target field holds sender index S clears only bit S of I's vector. irq[I] stays 1 while other bits remain set.
- R7: irq[T] falls on the cycle after T's source vector becomes empty.
- R8: Readback holds its value across raise, acknowledge and idle cycles.
- R9: While cmd_valid is 0, the opcode, issuer and target inputs change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 2 | Opcode: 0 raise, 1 status, 2 source, 3 acknowledge |
| cmd_issuer | input | ID_W | Number of the core issuing the command |
| cmd_target | input | ID_W | Destination core, or sender index for acknowledge |
| readback | output | NUM_CORES | Result of the most recent query |
| irq | output | NUM_CORES | Interrupt line per core, registered |

## Verification
A wrong source bit shows up at the ports in two ways. First, the affected interrupt line is wrong on the cycle after the command that caused the fault. Second, a status or source query returns the wrong readback one cycle after it is issued. The directed scenarios therefore follow every raise and acknowledge with queries from both sides, and look at irq right after each step. Acknowledges that leave other senders pending, and the final acknowledge that empties a vector, are the cases most likely to show a clear that reaches the wrong bit or the wrong row.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  typedef enum logic [1:0] {
    OP_RAISE  = 2'd0,
    OP_STATUS = 2'd1,
    OP_SOURCE = 2'd2,
    OP_ACK    = 2'd3
  } ipi_op_e;
endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode #(
  parameter int NUM_CORES = 4,
  parameter int ID_W = 2,
  localparam int CELLS = NUM_CORES * NUM_CORES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [ID_W-1:0]  cmd_issuer,
  input  logic [ID_W-1:0]  cmd_target,
  output logic [CELLS-1:0] set_bits,
  output logic [CELLS-1:0] clr_bits,
  output logic [CELLS-1:0] pick_bits,
  output logic             q_status,
  output logic             q_source
);
  import ipi_pkg::*;

  ipi_op_e op;
  logic    ids_ok;

  assign op     = ipi_op_e'(cmd_op);
  assign ids_ok = (int'(cmd_issuer) < NUM_CORES) && (int'(cmd_target) < NUM_CORES);

  assign q_status = cmd_valid && ids_ok && (op == OP_STATUS);
  assign q_source = cmd_valid && ids_ok && (op == OP_SOURCE);

  // cell index t*NUM_CORES+s : sender s pending on target t
  always_comb begin
    set_bits  = '0;
    clr_bits  = '0;
    pick_bits = '0;
    for (int t = 0; t < NUM_CORES; t++) begin
      for (int s = 0; s < NUM_CORES; s++) begin
        if (cmd_valid && ids_ok) begin
          if (op == OP_RAISE && cmd_target == ID_W'(t) && cmd_issuer == ID_W'(s))
            set_bits[t*NUM_CORES+s] = 1'b1;
          if (op == OP_ACK && cmd_issuer == ID_W'(t) && cmd_target == ID_W'(s))
            clr_bits[t*NUM_CORES+s] = 1'b1;
        end
        if (cmd_target == ID_W'(t) && cmd_issuer == ID_W'(s))
          pick_bits[t*NUM_CORES+s] = 1'b1;
      end
    end
  end

  // R2/R6: a single command touches at most one cell
  assert_single_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({set_bits, clr_bits}));
endmodule

// File: rtl/ipi_source_bank.sv
module ipi_source_bank #(
  parameter int NUM_CORES = 4,
  localparam int CELLS = NUM_CORES * NUM_CORES
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CELLS-1:0]     set_bits,
  input  logic [CELLS-1:0]     clr_bits,
  output logic [CELLS-1:0]     src_flat,
  output logic [NUM_CORES-1:0] irq
);
  logic [CELLS-1:0]     src_q, src_nx;
  logic [NUM_CORES-1:0] irq_nx, irq_q;

  assign src_nx = (src_q & ~clr_bits) | set_bits;

  generate
    for (genvar t = 0; t < NUM_CORES; t++) begin : g_line
      assign irq_nx[t] = |src_nx[t*NUM_CORES +: NUM_CORES];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= '0;
      irq_q <= '0;
    end else begin
      src_q <= src_nx;
      irq_q <= irq_nx;
    end
  end

  assign src_flat = src_q;
  assign irq      = irq_q;

  generate
    for (genvar c = 0; c < CELLS; c++) begin : g_cell_chk
      assert_set_lands_R2: assert property (@(posedge clk) disable iff (rst)
        set_bits[c] |=> src_q[c]);
      assert_clear_lands_R6: assert property (@(posedge clk) disable iff (rst)
        clr_bits[c] |=> !src_q[c]);
    end
  endgenerate

  assert_idle_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (set_bits == '0 && clr_bits == '0) |=> $stable(src_q));
endmodule

// File: rtl/ipi_readback.sv
module ipi_readback #(
  parameter int NUM_CORES = 4,
  parameter int ID_W = 2,
  localparam int CELLS = NUM_CORES * NUM_CORES
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 q_status,
  input  logic                 q_source,
  input  logic [ID_W-1:0]      cmd_issuer,
  input  logic [CELLS-1:0]     pick_bits,
  input  logic [CELLS-1:0]     src_flat,
  output logic [NUM_CORES-1:0] readback
);
  logic [NUM_CORES-1:0] own_row;
  logic                 status_bit;
  logic [NUM_CORES-1:0] rb_q;

  always_comb begin
    own_row = '0;
    for (int r = 0; r < NUM_CORES; r++)
      if (cmd_issuer == ID_W'(r)) own_row = src_flat[r*NUM_CORES +: NUM_CORES];
  end

  assign status_bit = |(src_flat & pick_bits);

  always_ff @(posedge clk) begin
    if (rst)           rb_q <= '0;
    else if (q_status) rb_q <= NUM_CORES'(status_bit);
    else if (q_source) rb_q <= own_row;
  end

  assign readback = rb_q;

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !(q_status || q_source) |=> $stable(rb_q));
  assert_status_narrow_R3: assert property (@(posedge clk) disable iff (rst)
    q_status |=> (rb_q >> 1) == '0);
endmodule

// File: rtl/ipi_unit.sv
module ipi_unit #(
  parameter int NUM_CORES = 4,
  localparam int ID_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int CELLS = NUM_CORES * NUM_CORES
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  input  logic [1:0]           cmd_op,
  input  logic [ID_W-1:0]      cmd_issuer,
  input  logic [ID_W-1:0]      cmd_target,
  output logic [NUM_CORES-1:0] readback,
  output logic [NUM_CORES-1:0] irq
);
  import ipi_pkg::*;

  logic [CELLS-1:0] set_bits, clr_bits, pick_bits, src_flat;
  logic             q_status, q_source;

  ipi_cmd_decode #(.NUM_CORES(NUM_CORES), .ID_W(ID_W)) u_decode (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_issuer(cmd_issuer), .cmd_target(cmd_target),
    .set_bits(set_bits), .clr_bits(clr_bits), .pick_bits(pick_bits),
    .q_status(q_status), .q_source(q_source)
  );

  ipi_source_bank #(.NUM_CORES(NUM_CORES)) u_bank (
    .clk(clk), .rst(rst), .set_bits(set_bits), .clr_bits(clr_bits),
    .src_flat(src_flat), .irq(irq)
  );

  ipi_readback #(.NUM_CORES(NUM_CORES), .ID_W(ID_W)) u_rb (
    .clk(clk), .rst(rst), .q_status(q_status), .q_source(q_source),
    .cmd_issuer(cmd_issuer), .pick_bits(pick_bits), .src_flat(src_flat),
    .readback(readback)
  );

  logic [NUM_CORES-1:0] issuer_row;
  always_comb begin
    issuer_row = '0;
    for (int r = 0; r < NUM_CORES; r++)
      if (cmd_issuer == ID_W'(r)) issuer_row = src_flat[r*NUM_CORES +: NUM_CORES];
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (irq == '0 && readback == '0));

  assert_raise_asserts_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_RAISE) |=> irq[$past(cmd_target)]);

  assert_last_ack_drops_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_ACK &&
     issuer_row == (NUM_CORES'(1) << cmd_target)) |=> !irq[$past(cmd_issuer)]);
endmodule

// File: tb/ipi_unit_bench.sv
module ipi_unit_bench;
  localparam int N = 4;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = 2'd0;
  logic [IW-1:0] cmd_issuer = '0;
  logic [IW-1:0] cmd_target = '0;
  logic [N-1:0]  readback, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  ipi_unit #(.NUM_CORES(N)) u_ipi_unit (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_issuer(cmd_issuer), .cmd_target(cmd_target),
    .readback(readback), .irq(irq)
  );

  task automatic check(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, got, exp);
    end
  endtask

  // drive at negedge, capture at posedge, return at the next negedge
  task automatic cmd(input logic [1:0] op, input int who, input int tgt);
    @(negedge clk);
    cmd_valid  = 1'b1;
    cmd_op     = op;
    cmd_issuer = IW'(who);
    cmd_target = IW'(tgt);
    @(negedge clk);
    cmd_valid  = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 irq after reset", irq, 4'b0000);
    check("R1 readback after reset", readback, 4'b0000);
    cmd(2'd2, 2, 0);
    check("R1 source vector empty", readback, 4'b0000);
  endtask

  task automatic t_single_raise;
    cmd(2'd0, 1, 2);
    check("R2 irq after raise 1->2", irq, 4'b0100);
    cmd(2'd1, 1, 2);
    check("R3 status pending 1->2", readback, 4'b0001);
    cmd(2'd1, 3, 2);
    check("R3 status idle 3->2", readback, 4'b0000);
    cmd(2'd2, 2, 0);
    check("R4 source of core2", readback, 4'b0010);
  endtask

  task automatic t_merge;
    cmd(2'd0, 0, 2);
    cmd(2'd0, 3, 2);
    check("R5 single line for merged raises", irq, 4'b0100);
    cmd(2'd2, 2, 0);
    check("R5 merged source vector", readback, 4'b1011);
  endtask

  task automatic t_idle_ignored;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'd0; cmd_issuer = 2'd1; cmd_target = 2'd0;
    @(negedge clk);
    cmd_op = 2'd3; cmd_issuer = 2'd2; cmd_target = 2'd0;
    @(negedge clk);
    cmd_op = 2'd1;
    @(negedge clk);
    check("R9 irq unchanged by invalid cycles", irq, 4'b0100);
    check("R8 readback held while idle", readback, 4'b1011);
    cmd(2'd2, 2, 0);
    check("R9 vector unchanged by invalid ack", readback, 4'b1011);
  endtask

  task automatic t_ack_partial;
    cmd(2'd3, 2, 1);
    check("R8 readback held across ack", readback, 4'b1011);
    check("R6 irq stays with other senders", irq, 4'b0100);
    cmd(2'd2, 2, 0);
    check("R6 only sender 1 cleared", readback, 4'b1001);
    cmd(2'd1, 1, 2);
    check("R3 status after ack 1->2", readback, 4'b0000);
    cmd(2'd0, 1, 0);
    check("R8 readback held across raise", readback, 4'b0000);
    check("R2 second target line", irq, 4'b0101);
  endtask

  task automatic t_ack_all;
    cmd(2'd3, 2, 0);
    check("R6 irq after one of two acks", irq, 4'b0101);
    cmd(2'd3, 2, 3);
    check("R7 line 2 drops when empty", irq, 4'b0001);
    cmd(2'd3, 0, 1);
    check("R7 line 0 drops when empty", irq, 4'b0000);
    cmd(2'd2, 2, 0);
    check("R7 source vector empty", readback, 4'b0000);
  endtask

  task automatic t_self_and_ack_absent;
    cmd(2'd0, 3, 3);
    check("R2 self raise", irq, 4'b1000);
    cmd(2'd2, 3, 0);
    check("R4 self source bit", readback, 4'b1000);
    cmd(2'd3, 3, 0);
    check("R6 ack of absent sender keeps line", irq, 4'b1000);
    cmd(2'd3, 3, 3);
    check("R7 self ack drops line", irq, 4'b0000);
  endtask

  initial begin
    t_reset();
    t_single_raise();
    t_merge();
    t_idle_ignored();
    t_ack_partial();
    t_ack_all();
    t_self_and_ack_absent();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule